// File: doc/BRIEF.md
# Clock Compensation Rate-Match FIFO

This block is a receive-side elastic buffer. It carries 20-bit parallel code groups from the recovered receive clock into the local system clock. The two clocks run at nearly the same frequency but are not locked, so the buffer level drifts. The block corrects the drift only by acting on skip code groups, which appear in inter-packet gaps and idle streams.

- When the buffer is filling, an arriving skip word is dropped instead of stored.
- When the buffer is draining and the last word handed out was a skip, that skip is repeated without consuming a stored word.

A skip is recognised by two programmable encodings, one for each running disparity. Data words are never added or removed.

Write and read pointers cross between the clock domains as Gray code through two-flop synchronisers. Each side therefore works from a slightly stale, conservative view of the other side's pointer. After reset, and after any underflow, the read side withholds output until half the buffer has filled. This re-centres the level. The read side consumes one word per system clock once it is running.

Top module: `rate_match_fifo`

## Requirements
- R1: While no overflow occurs, every non-skip word written appears at `rd_data` with `rd_valid` high, exactly once and in write order.
- R2: A word is a skip when it equals `skip_pos` or `skip_neg`; both encodings are recognised and treated alike.
- R3: When the write-side fill level is above `HI_MARK` (default 12) and the arriving word is a skip, that word is discarded.
- R4: When the read-side fill level is below `LO_MARK` (default 4), the buffer holds at least one word, and the last word read from storage was a skip, the block outputs that skip again with `rd_valid` high. `rd_data` is unchanged and no stored word is consumed.
- R5: At most one extra copy is inserted per skip word read from storage. No non-skip word is ever inserted or discarded by compensation.
- R6: After reset and after an underflow, `rd_valid` stays low and `rd_data` holds its value until the read-side fill level reaches DEPTH/2 (default 8).
- R7: `full` is high while the write-side view holds DEPTH words. A non-skip word arriving while full is lost, and `ovf_pulse` goes high for one write clock in the following cycle.
- R8: `empty` is high while the read-side fill level is zero. If the read side is running and finds the buffer empty, then one system clock later:
  - `unf_pulse` is high for one cycle;
  - `rd_valid` is low;
  - `rd_data` still holds the last word;
  - the read side returns to its withholding state of R6.
- R9: During reset `rd_valid`, `rd_data`, `full`, `ovf_pulse` and `unf_pulse` are zero and `empty` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_valid | input | 1 | A code group is present on `wr_data` |
| wr_data | input | 20 | Incoming code group |
| skip_pos | input | 20 | Skip encoding for positive running disparity |
| skip_neg | input | 20 | Skip encoding for negative running disparity |
| rd_clk | input | 1 | Local system clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_data | output | 20 | Outgoing code group, held when not valid |
| rd_valid | output | 1 | `rd_data` carries a word this cycle |
| full | output | 1 | Write-side view of the buffer is full |
| empty | output | 1 | Read-side view of the buffer is empty |
| ovf_pulse | output | 1 | One-cycle pulse: a word was lost to overflow |
| unf_pulse | output | 1 | One-cycle pulse: the running read side underflowed |

## Verification
The assertions take two things for granted.
- `skip_pos` and `skip_neg` are static while the block runs. They are sampled in both clock domains without synchronisation.
- Data words never equal either skip encoding. Otherwise a data word would legally be compensated.

The stimulus drives fixed, distinct skip encodings for the whole run. It builds data words with a leading nibble that neither encoding uses. Both resets are asserted and released together. Clock offsets of about two percent keep the drift within what the watermarks can absorb, except in the stages that deliberately starve or flood the buffer.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

  localparam int CODE_W = 20;

  typedef logic [CODE_W-1:0] code_t;

  // binary to reflected Gray
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray back to binary
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // skip recognition against both disparity encodings
  function automatic logic code_is_skip(input code_t w, input code_t p, input code_t n);
    return (w == p) || (w == n);
  endfunction

endpackage

// File: rtl/rmf_sync.sv
module rmf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/rmf_wr_ctrl.sv
module rmf_wr_ctrl
  import rmf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int HI_MARK = 12,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  code_t         wr_data,
  input  code_t         skip_pos,
  input  code_t         skip_neg,
  input  logic [PW-1:0] rptr_gray_s,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wptr_gray,
  output logic          push,
  output logic          drop,
  output logic          ovf,
  output logic          full,
  output logic          ovf_pulse
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HI_P    = PW'(HI_MARK);

  logic [PW-1:0] wptr_q;
  logic [PW-1:0] wgray_q;
  logic [PW-1:0] rptr_b;
  logic [PW-1:0] fill;
  logic          is_skp;

  assign rptr_b = PW'(gray2bin(32'(rptr_gray_s)));
  assign fill   = wptr_q - rptr_b;
  assign is_skp = code_is_skip(wr_data, skip_pos, skip_neg);

  assign full = (fill == DEPTH_P);
  assign drop = wr_valid && is_skp && (fill > HI_P);
  assign push = wr_valid && !drop && !full;
  assign ovf  = wr_valid && !drop && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      wgray_q   <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ovf;
      if (push) begin
        wptr_q  <= wptr_q + 1'b1;
        wgray_q <= PW'(bin2gray(32'(wptr_q + 1'b1)));
      end
    end
  end

  assign waddr     = wptr_q[AW-1:0];
  assign wptr_gray = wgray_q;
endmodule

// File: rtl/rmf_rd_ctrl.sv
module rmf_rd_ctrl
  import rmf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LO_MARK = 4,
  localparam int AW  = $clog2(DEPTH),
  localparam int PW  = AW + 1,
  localparam int MID = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wptr_gray_s,
  input  code_t         mem_word,
  input  code_t         skip_pos,
  input  code_t         skip_neg,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr_gray,
  output code_t         rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          unf_pulse,
  output logic          pop,
  output logic          ins,
  output logic          unf
);
  localparam logic [PW-1:0] MID_P = PW'(MID);
  localparam logic [PW-1:0] LO_P  = PW'(LO_MARK);

  logic [PW-1:0] rptr_q, rgray_q, wptr_b, fill;
  logic          primed_q, primed_d;
  logic          last_skip_q, last_skip_d;
  logic          ins_done_q, ins_done_d;
  logic          valid_d;
  code_t         data_q, data_d;

  assign wptr_b = PW'(gray2bin(32'(wptr_gray_s)));
  assign fill   = wptr_b - rptr_q;
  assign empty  = (fill == '0);

  always_comb begin
    pop         = 1'b0;
    ins         = 1'b0;
    unf         = 1'b0;
    primed_d    = primed_q;
    valid_d     = 1'b0;
    data_d      = data_q;
    last_skip_d = last_skip_q;
    ins_done_d  = ins_done_q;
    if (!primed_q) begin
      if (fill >= MID_P) primed_d = 1'b1;
    end else if (empty) begin
      unf      = 1'b1;
      primed_d = 1'b0;
    end else if ((fill < LO_P) && last_skip_q && !ins_done_q) begin
      ins        = 1'b1;
      valid_d    = 1'b1;
      ins_done_d = 1'b1;
    end else begin
      pop         = 1'b1;
      valid_d     = 1'b1;
      data_d      = mem_word;
      last_skip_d = code_is_skip(mem_word, skip_pos, skip_neg);
      ins_done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q      <= '0;
      rgray_q     <= '0;
      primed_q    <= 1'b0;
      last_skip_q <= 1'b0;
      ins_done_q  <= 1'b0;
      data_q      <= '0;
      rd_valid    <= 1'b0;
      unf_pulse   <= 1'b0;
    end else begin
      primed_q    <= primed_d;
      last_skip_q <= last_skip_d;
      ins_done_q  <= ins_done_d;
      data_q      <= data_d;
      rd_valid    <= valid_d;
      unf_pulse   <= unf;
      if (pop) begin
        rptr_q  <= rptr_q + 1'b1;
        rgray_q <= PW'(bin2gray(32'(rptr_q + 1'b1)));
      end
    end
  end

  assign raddr     = rptr_q[AW-1:0];
  assign rptr_gray = rgray_q;
  assign rd_data   = data_q;
endmodule

// File: rtl/rate_match_fifo.sv
module rate_match_fifo
  import rmf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [CODE_W-1:0] skip_pos,
  input  logic [CODE_W-1:0] skip_neg,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic [CODE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              empty,
  output logic              ovf_pulse,
  output logic              unf_pulse
);
  // named internal events, brought out for the checker
  logic wr_push, wr_drop, wr_ovf;
  logic rd_pop, rd_ins, rd_unf;

  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  code_t         store [DEPTH];

  rmf_wr_ctrl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK)) i_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .skip_pos(skip_pos), .skip_neg(skip_neg), .rptr_gray_s(rgray_s),
    .waddr(waddr), .wptr_gray(wgray), .push(wr_push), .drop(wr_drop),
    .ovf(wr_ovf), .full(full), .ovf_pulse(ovf_pulse)
  );

  rmf_sync #(.W(PW)) i_sync_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));
  rmf_sync #(.W(PW)) i_sync_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));

  always_ff @(posedge wr_clk) begin
    if (wr_push) store[waddr] <= wr_data;
  end

  rmf_rd_ctrl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK)) i_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .wptr_gray_s(wgray_s), .mem_word(store[raddr]),
    .skip_pos(skip_pos), .skip_neg(skip_neg), .raddr(raddr), .rptr_gray(rgray),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .unf_pulse(unf_pulse),
    .pop(rd_pop), .ins(rd_ins), .unf(rd_unf)
  );
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker
  import rmf_pkg::*;
(
  input logic  wr_clk,
  input logic  wr_rst_n,
  input logic  rd_clk,
  input logic  rd_rst_n,
  input logic  wr_valid,
  input code_t wr_data,
  input code_t skip_pos,
  input code_t skip_neg,
  input code_t rd_data,
  input logic  rd_valid,
  input logic  full,
  input logic  ovf_pulse,
  input logic  unf_pulse,
  input logic  wr_push,
  input logic  wr_drop,
  input logic  wr_ovf,
  input logic  rd_pop,
  input logic  rd_ins,
  input logic  rd_unf
);
  // R3
  drop_only_skip_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_drop |-> (wr_valid && (wr_data == skip_pos || wr_data == skip_neg)));

  // R7
  no_store_when_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_push |-> !full);

  // R7
  ovf_reported_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_ovf |=> ovf_pulse);

  // R4
  insert_repeats_skip_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_ins |-> (rd_valid && (rd_data == skip_pos || rd_data == skip_neg)));

  // R4
  insert_holds_data_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_ins |=> (rd_valid && $stable(rd_data)));

  // R5
  single_insert_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_ins |=> !rd_ins);

  // R8
  underflow_seen_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_unf |=> (!rd_valid && unf_pulse && $stable(rd_data)));

  // R1
  read_events_exclusive_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $onehot0({rd_pop, rd_ins, rd_unf}));
endmodule

bind rate_match_fifo rmf_checker i_rmf_checker (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_valid(wr_valid), .wr_data(wr_data), .skip_pos(skip_pos), .skip_neg(skip_neg),
  .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .ovf_pulse(ovf_pulse),
  .unf_pulse(unf_pulse), .wr_push(wr_push), .wr_drop(wr_drop), .wr_ovf(wr_ovf),
  .rd_pop(rd_pop), .rd_ins(rd_ins), .rd_unf(rd_unf)
);

// File: tb/test_rate_match_fifo.sv
`timescale 1ns/1ps
module test_rate_match_fifo;
  localparam int DEPTH = 16;
  localparam int MID   = DEPTH / 2;
  localparam logic [19:0] SKP_P = 20'h3E8C1;
  localparam logic [19:0] SKP_N = 20'hC1735;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_valid = 0;
  logic [19:0] wr_data = '0;
  logic [19:0] rd_data;
  logic rd_valid, full, empty, ovf_pulse, unf_pulse;

  real wr_half = 2.45;
  always #(wr_half) wr_clk = ~wr_clk;
  always #2.5 rd_clk = ~rd_clk;            // 200 MHz system clock

  rate_match_fifo i_rate_match_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .skip_pos(SKP_P), .skip_neg(SKP_N), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
    .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
  );

  int checks = 0, errors = 0;
  int mode = 0;                            // 0 idle, 1 data with skips, 2 data only
  bit chk_en = 0;
  int n = 0, writes = 0;
  logic [19:0] q[$];
  logic [19:0] last_out = '0;
  bit have_out = 0, prev_ins = 0, first_seen = 0;
  int dels_p = 0, dels_n = 0, inss = 0, ovf_cnt = 0, unf_cnt = 0, full_cnt = 0;
  int cyc = 0;

  function automatic bit skp(logic [19:0] w);
    return w == SKP_P || w == SKP_N;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic note_del(logic [19:0] w);
    if (w == SKP_P) dels_p++; else dels_n++;
  endtask

  // write-side driver
  always @(negedge wr_clk) begin
    if (mode == 0 || !wr_rst_n) begin
      wr_valid <= 0;
    end else begin
      logic [19:0] w;
      if (mode == 1 && n % 8 == 7) w = ((n / 8) % 2 == 0) ? SKP_P : SKP_N;
      else w = {4'h1, n[15:0]};
      n++;
      writes++;
      wr_valid <= 1;
      wr_data  <= w;
      q.push_back(w);
    end
    if (wr_rst_n && ovf_pulse) ovf_cnt++;
    if (wr_rst_n && full) full_cnt++;
  end

  // read-side reference comparison
  always @(negedge rd_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rd_rst_n && unf_pulse) unf_cnt++;
    if (chk_en && rd_valid) begin
      logic [19:0] w;
      w = rd_data;
      if (!first_seen) begin
        first_seen = 1;
        // R6: no output before half the buffer was written
        check(writes >= MID + 1, "R6", "writes before first valid", writes, MID + 1);
      end
      if (skp(w)) begin
        int idx;
        idx = -1;
        for (int i = 0; i < q.size() && skp(q[i]); i++) begin
          if (q[i] == w) begin idx = i; break; end
        end
        if (idx >= 0) begin
          // R2/R3: skipped-over skips were deleted
          for (int i = 0; i < idx; i++) note_del(q[i]);
          for (int i = 0; i <= idx; i++) void'(q.pop_front());
          prev_ins = 0;
          checks++;
        end else if (have_out && w == last_out) begin
          // R5: no second insertion in a row
          check(!prev_ins, "R5", "double insertion", 1, 0);
          inss++;
          prev_ins = 1;
        end else begin
          check(0, "R1", "unexpected skip word", w, q.size() ? q[0] : 0);
        end
      end else begin
        while (q.size() && skp(q[0])) note_del(q.pop_front());
        // R1 / R5: data in order, never duplicated or lost
        check(q.size() > 0 && q[0] == w, "R1", "data word order", w, q.size() ? q[0] : 0);
        if (q.size() > 0 && q[0] == w) void'(q.pop_front());
        prev_ins = 0;
      end
      last_out = w;
      have_out = 1;
    end
  end

  task automatic do_reset();
    chk_en = 0;
    mode = 0;
    wr_rst_n = 0;
    rd_rst_n = 0;
    repeat (4) @(negedge rd_clk);
    q.delete();
    writes = 0; first_seen = 0; have_out = 0; prev_ins = 0;
    // R9
    check(rd_valid == 0 && rd_data == 0, "R9", "reset outputs", {rd_valid, rd_data}, 0);
    check(empty == 1 && full == 0, "R9", "reset flags", {empty, full}, 2);
    check(ovf_pulse == 0 && unf_pulse == 0, "R9", "reset pulses", {ovf_pulse, unf_pulse}, 0);
    @(negedge rd_clk);
    wr_rst_n = 1;
    rd_rst_n = 1;
    chk_en = 1;
  endtask

  initial begin
    logic [19:0] held;
    do_reset();
    // R6: nothing comes out while idle
    repeat (20) @(negedge rd_clk);
    check(rd_valid == 0, "R6", "valid while idle after reset", rd_valid, 0);

    // write clock fast: deletion
    wr_half = 2.45;
    mode = 1;
    repeat (3000) @(negedge rd_clk);
    check(dels_p > 0, "R3", "positive skip deletions", dels_p, 1);
    check(dels_n > 0, "R2", "negative skip deletions", dels_n, 1);

    // write clock slow: insertion
    wr_half = 2.55;
    repeat (3000) @(negedge rd_clk);
    check(inss > 0, "R4", "insertions seen", inss, 1);
    check(ovf_cnt == 0, "R3", "no overflow under compensation", ovf_cnt, 0);
    check(unf_cnt == 0, "R4", "no underflow under compensation", unf_cnt, 0);

    // write clock fast with no skips: overflow
    chk_en = 0;
    wr_half = 2.45;
    mode = 2;
    repeat (1500) @(negedge rd_clk);
    check(full_cnt > 0, "R7", "full flag seen", full_cnt, 1);
    check(ovf_cnt > 0, "R7", "overflow pulse seen", ovf_cnt, 1);

    // starvation: underflow
    do_reset();
    unf_cnt = 0;
    mode = 2;
    repeat (40) @(negedge rd_clk);
    mode = 0;
    while (!unf_pulse) @(negedge rd_clk);
    held = last_out;
    check(rd_valid == 0, "R8", "valid at underflow", rd_valid, 0);
    check(rd_data == held, "R8", "data held at underflow", rd_data, held);
    check(empty == 1, "R8", "empty at underflow", empty, 1);
    repeat (20) @(negedge rd_clk);
    check(unf_cnt == 1, "R8", "single underflow pulse", unf_cnt, 1);
    check(rd_valid == 0 && rd_data == held, "R6", "held after underflow", rd_data, held);
    // refill: output resumes only after re-priming
    first_seen = 0;
    writes = 0;
    mode = 2;
    repeat (60) @(negedge rd_clk);
    check(first_seen == 1, "R6", "output resumed after refill", first_seen, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule